// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers interrupt requests from eight peripheral lines and turns them into one request toward the processor. Line 0 has the highest priority and line 7 the lowest. When the processor answers on its single acknowledge input, the controller places an 8-bit vector on the data bus for that cycle. The vector is a base parameter plus the number of the chosen line, and the processor uses it to find the handler.

An in-service record tracks which lines are being handled. A line of higher priority than every in-service line may preempt the current service. Lines of equal or lower priority wait until end-of-interrupt pulses have cleared the in-service bits above them.

A role parameter selects single, master or slave operation. Two instances chain by feeding the slave's request into master line 2, which gives fifteen usable lines. When the master acknowledges line 2, it raises a select output and stays off the bus. The slave, selected by that output, supplies the vector instead.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Each of the eight request lines is level-sensitive. A line counts as pending when it was high at the most recent rising clock edge.
- R2: Line 0 has the highest priority and line 7 the lowest. The selected line is the lowest-numbered pending line whose number is below that of every in-service line.
- R3: `int_req` is high exactly when a selected line exists.
- R4: During a cycle in which `int_ack` is high and a line is selected, `vec_oe` is high and `vec_out` equals `VEC_BASE` plus the line number. In every other cycle `vec_oe` is low and `vec_out` is zero. `VEC_BASE` is a multiple of 8.
- R5: An acknowledge sets the in-service bit of the selected line. A pending line of equal or lower priority than the highest-priority in-service line does not raise `int_req`. A pending line of higher priority does raise it, which preempts the current service.
- R6: When several lines are pending together, successive acknowledges (each followed by end-of-interrupt and removal of the serviced line) return them in ascending line-number order.
- R7: An `eoi` pulse clears only the lowest-numbered set in-service bit. It has no effect when no bit is set.
- R8: In master role, line 2 is the cascade input. An acknowledge that selects line 2 drives `casc_sel` high and keeps `vec_oe` low for that cycle. In slave role, an acknowledge takes effect only while `sel_in` is high. A slave that is not selected changes no state and drives no vector.
- R9: Reset clears all pending and in-service bits. It holds `int_req`, `vec_oe` and `casc_sel` low.
- R10: An acknowledge while no line is selected leaves the in-service record unchanged and drives no vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 8 | Peripheral request lines, level-sensitive; bit 2 is the cascade input in master role |
| eoi | input | 1 | End-of-interrupt pulse |
| int_ack | input | 1 | Acknowledge from the processor |
| sel_in | input | 1 | Slave select from the master (used in slave role only) |
| int_req | output | 1 | Request to the processor |
| vec_oe | output | 1 | Vector bus drive enable |
| vec_out | output | 8 | Vector value, zero when not driven |
| casc_sel | output | 1 | Master selects the slave to supply the vector |

## Verification
The bench targets preemption. A higher line raised during service must request at once, while equal and lower lines stay silent. A design that compares priority with the wrong sense would either never preempt or would re-request the line already in service. End-of-interrupt is checked with two in-service bits set, because clearing the wrong bit leaves the next lower line blocked. An acknowledge is sent with nothing selected, and then a low-priority line is serviced; a design that sets a stray in-service bit on that acknowledge would block the line. In the chained pair, a master acknowledge of its own line must leave the slave untouched, so that the slave's later vector names its real pending line; and a master acknowledge of line 2 must yield the slave's vector with the master off the bus.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    ROLE_SINGLE = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } irq_role_e;

  localparam int CASCADE_LINE = 2;
endpackage

// File: rtl/irq_sample.sv
module irq_sample #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] irr_q, irr_d;

  always_comb begin
    irr_d = lines_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irr_q <= '0;
    else        irr_q <= irr_d;
  end

  assign irr_o = irr_q;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     irr_i,
  input  logic [N-1:0]     isr_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] elig;
  logic         seen;

  // A line is eligible only if no in-service bit at its own or higher priority.
  always_comb begin
    seen = 1'b0;
    elig = '0;
    for (int i = 0; i < N; i++) begin
      seen    = seen | isr_i[i];
      elig[i] = irr_i[i] & ~seen;
    end
  end

  always_comb begin
    valid_o = |elig;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             eoi_i,
  output logic [N-1:0]     isr_o
);
  logic [N-1:0] isr_q, isr_d, low_bit, set_mask;

  always_comb begin
    low_bit  = isr_q & (~isr_q + N'(1));
    set_mask = '0;
    if (set_en) set_mask[set_idx] = 1'b1;
    isr_d = isr_q;
    if (eoi_i) isr_d = isr_d & ~low_bit;
    isr_d = isr_d | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= isr_d;
  end

  assign isr_o = isr_q;

  // R7: an end-of-interrupt with a set bit and no new grant removes exactly one bit
  p_eoi_drops_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && (|isr_q) && !set_en) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1));

  // R5: a grant without end-of-interrupt adds one bit not already in service
  p_grant_adds_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !eoi_i) |=> ($countones(isr_q) == $countones($past(isr_q)) + 1));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int        NUM_LINES = 8,
  parameter int        VEC_W     = 8,
  parameter logic [7:0] VEC_BASE = 8'h20,
  parameter irq_role_e ROLE      = ROLE_SINGLE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       irq_in,
  input  logic             eoi,
  input  logic             int_ack,
  input  logic             sel_in,
  output logic             int_req,
  output logic             vec_oe,
  output logic [VEC_W-1:0] vec_out,
  output logic             casc_sel
);
  localparam int IDX_W = $clog2(NUM_LINES);

  logic [NUM_LINES-1:0] irr, isr;
  logic                 cand_valid, sel_ok, ack_take, casc_hit;
  logic [IDX_W-1:0]     cand_idx;

  irq_sample #(.N(NUM_LINES)) u_sample (
    .clk(clk), .rst_n(rst_n), .lines_i(irq_in[NUM_LINES-1:0]), .irr_o(irr)
  );

  irq_resolver #(.N(NUM_LINES), .IDX_W(IDX_W)) u_resolver (
    .irr_i(irr), .isr_i(isr), .valid_o(cand_valid), .idx_o(cand_idx)
  );

  irq_inservice #(.N(NUM_LINES), .IDX_W(IDX_W)) u_inservice (
    .clk(clk), .rst_n(rst_n), .set_en(ack_take), .set_idx(cand_idx),
    .eoi_i(eoi), .isr_o(isr)
  );

  assign sel_ok = sel_in | (ROLE != ROLE_SLAVE);

  generate
    if (ROLE == ROLE_MASTER) begin : g_master
      assign casc_hit = (cand_idx == IDX_W'(CASCADE_LINE));
    end else begin : g_leaf
      assign casc_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    ack_take = int_ack & cand_valid & sel_ok;
    int_req  = cand_valid;
    vec_oe   = ack_take & ~casc_hit;
    casc_sel = ack_take & casc_hit;
    vec_out  = vec_oe ? (VEC_W'(VEC_BASE) + VEC_W'(cand_idx)) : '0;
  end

  // R4: the vector is never driven outside an acknowledge
  p_vec_needs_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> int_ack);

  // R3: a request always has a sampled pending line behind it
  p_req_has_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (|irr));

  // R8: master hands the bus to the slave, never both
  p_casc_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    casc_sel |-> (!vec_oe && int_ack));

  // R10: with nothing selected the in-service record holds unless eoi clears it
  p_idle_ack_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !int_req && !eoi) |=> $stable(isr));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  import prio_irq_pkg::*;

  localparam logic [7:0] M_BASE = 8'h20;
  localparam logic [7:0] S_BASE = 8'h70;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_m = '0, irq_s = '0;
  logic       eoi_m = 1'b0, eoi_s = 1'b0, ack = 1'b0;
  logic       m_req, m_oe, m_casc, s_req, s_oe, s_casc;
  logic [7:0] m_vec, s_vec, bus, m_lines;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign m_lines = {irq_m[7:3], s_req, irq_m[1:0]};
  assign bus = m_vec | s_vec;

  prio_irq_ctrl #(.VEC_BASE(M_BASE), .ROLE(ROLE_MASTER)) u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(m_lines), .eoi(eoi_m), .int_ack(ack),
    .sel_in(1'b0), .int_req(m_req), .vec_oe(m_oe), .vec_out(m_vec), .casc_sel(m_casc)
  );

  prio_irq_ctrl #(.VEC_BASE(S_BASE), .ROLE(ROLE_SLAVE)) u_slave (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_s), .eoi(eoi_s), .int_ack(ack),
    .sel_in(m_casc), .int_req(s_req), .vec_oe(s_oe), .vec_out(s_vec), .casc_sel(s_casc)
  );

  // Behavioural reference state
  bit [7:0] r_mirr, r_misr, r_sirr, r_sisr;

  function automatic int pick(bit [7:0] irr, bit [7:0] isr);
    for (int i = 0; i < 8; i++) begin
      if (isr[i]) return -1;
      if (irr[i]) return i;
    end
    return -1;
  endfunction

  function automatic bit [7:0] drop_low(bit [7:0] isr);
    for (int i = 0; i < 8; i++) if (isr[i]) begin isr[i] = 1'b0; return isr; end
    return isr;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_mirr = '0; r_misr = '0; r_sirr = '0; r_sisr = '0;
    end else begin
      int mc, sc;
      bit mt, st, sreq;
      mc = pick(r_mirr, r_misr);
      sc = pick(r_sirr, r_sisr);
      sreq = (sc >= 0);
      mt = ack && (mc >= 0);
      st = mt && (mc == 2) && (sc >= 0);
      if (eoi_m) r_misr = drop_low(r_misr);
      if (mt) r_misr[mc] = 1'b1;
      if (eoi_s) r_sisr = drop_low(r_sisr);
      if (st) r_sisr[sc] = 1'b1;
      r_mirr = {irq_m[7:3], sreq, irq_m[1:0]};
      r_sirr = irq_s;
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int mc, sc, ebus;
      bit mt, ecasc, emoe, esoe;
      mc = pick(r_mirr, r_misr);
      sc = pick(r_sirr, r_sisr);
      mt = ack && (mc >= 0);
      ecasc = mt && (mc == 2);
      emoe = mt && (mc != 2);
      esoe = ecasc && (sc >= 0);
      ebus = emoe ? (M_BASE + mc) : (esoe ? (S_BASE + sc) : 0);
      chk("R3 master int_req", m_req, mc >= 0);
      chk("R3 slave int_req", s_req, sc >= 0);
      chk("R4 master vec_oe", m_oe, emoe);
      chk("R8 casc_sel", m_casc, ecasc);
      chk("R8 slave vec_oe", s_oe, esoe);
      chk("R4 vector bus", bus, ebus);
    end
  end

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic do_ack(string tag, int exp_bus);
    ack = 1'b1;
    #1 chk(tag, bus, exp_bus);
    tick();
    ack = 1'b0;
  endtask

  task automatic eoi_both(bit m, bit s);
    eoi_m = m; eoi_s = s;
    tick();
    eoi_m = 1'b0; eoi_s = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R9 reset int_req", m_req, 0);
    chk("R9 reset vec_oe", m_oe | s_oe, 0);
    #1 rst_n = 1'b1;
    tick();

    // R1/R2: single line request and vector
    irq_m = 8'h20;
    tick();
    #1 chk("R1 line5 sampled", m_req, 1);
    #0 do_ack("R4 vector line5", M_BASE + 5);
    #1 chk("R5 equal priority blocked", m_req, 0);
    irq_m = 8'h60;
    tick();
    #1 chk("R5 lower line waits", m_req, 0);
    irq_m = 8'h62;
    tick();
    #1 chk("R5 higher preempts", m_req, 1);
    do_ack("R2 preempt vector line1", M_BASE + 1);
    irq_m = 8'h60;
    eoi_both(1, 0);
    #1 chk("R7 eoi clears line1 only", m_req, 0);
    irq_m = 8'h40;
    eoi_both(1, 0);
    #1 chk("R7 second eoi frees line6", m_req, 1);
    do_ack("R7 vector line6", M_BASE + 6);
    irq_m = 8'h00;
    eoi_both(1, 0);

    // R6: simultaneous lines 3,4,7
    irq_m = 8'h98;
    tick();
    do_ack("R6 first is line3", M_BASE + 3);
    irq_m = 8'h90; eoi_both(1, 0);
    do_ack("R6 second is line4", M_BASE + 4);
    irq_m = 8'h80; eoi_both(1, 0);
    do_ack("R6 third is line7", M_BASE + 7);
    irq_m = 8'h00; eoi_both(1, 0);
    eoi_both(1, 0);

    // R10: acknowledge with nothing selected
    ack = 1'b1;
    #1 chk("R10 no vector on idle ack", m_oe, 0);
    tick();
    ack = 1'b0;
    irq_m = 8'h80;
    tick();
    #1 chk("R10 state intact, line7 requests", m_req, 1);
    do_ack("R10 vector line7", M_BASE + 7);
    irq_m = 8'h00; eoi_both(1, 0);

    // R8: cascade through master line 2
    irq_s = 8'h40;
    tick();
    #1 chk("R8 slave request", s_req, 1);
    tick();
    #1 chk("R8 master sees cascade line", m_req, 1);
    ack = 1'b1;
    #1 chk("R8 casc_sel on line2 ack", m_casc, 1);
    chk("R8 master off bus", m_oe, 0);
    chk("R8 slave vector", bus, S_BASE + 6);
    tick();
    ack = 1'b0;
    irq_s = 8'h00;
    eoi_both(1, 1);
    tick();

    // R8: unselected slave ignores master's own acknowledge
    irq_s = 8'h10; irq_m = 8'h01;
    tick(); tick();
    do_ack("R8 master line0 ahead of cascade", M_BASE + 0);
    irq_m = 8'h00; eoi_both(1, 0);
    #1 chk("R8 cascade now requests", m_req, 1);
    do_ack("R8 slave line4 untouched earlier", S_BASE + 4);
    irq_s = 8'h00;
    eoi_both(1, 1);
    tick(); tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule